// File: doc/BRIEF.md
# Reloadable PWM Timer Channel

This block is one 24-bit timer channel running in pulse-width-modulation mode. An up-counter starts from a programmable load value. It advances by one on every cycle in which the timer clock enable `tick` is high and the channel is enabled. The single output `pwm_out` toggles in two places: when the counter matches the compare value, and when the counter passes full scale. The load value therefore sets the period, and the compare value sets where the active phase begins.

On each compare match the channel copies the counter into a capture register and sets a compare status flag. On each full-scale crossing it sets an overflow status flag. Each flag can drive a level interrupt request. An inversion bit selects the level the output takes when the channel starts, which flips the polarity of the whole waveform. Reload can be switched off, in which case the counter wraps through zero instead of returning to the load value. Software reaches the channel through a small register port with four word addresses. Writes take effect on the clock edge and reads are combinational.

Top module: `pwm_timer_chan`

## Requirements
- R1: While enabled, the counter advances by exactly one on each clock edge where `tick` is high. It holds on edges where `tick` is low.
- R2: A write to address 0 that sets bit 0 (enable) while the channel is disabled loads the counter with the load register (address 1) at that same edge. It also drives `pwm_out` to the written bit 2 (invert) at that edge.
- R3: A tick taken while the counter equals the compare register (address 2) toggles `pwm_out`, sets the compare flag (address 0 bit 8) and copies the counter into the capture register (read-only, address 3).
- R4: A tick taken while the counter is all-ones toggles `pwm_out` and sets the overflow flag (address 0 bit 9). The next counter value is the load register if reload (address 0 bit 1) is set, and zero otherwise.
- R5: With reload on, the period is (all-ones − load + 1) ticks. With invert clear, `pwm_out` is high for (all-ones − compare) ticks of each period. Setting invert swaps the high and low phases.
- R6: `cmp_irq` is high exactly when the compare flag and the compare interrupt enable (address 0 bit 3) are both set. `ovf_irq` is high exactly when the overflow flag and the overflow interrupt enable (address 0 bit 4) are both set.
- R7: Writing a one to bit 8 or bit 9 of address 0 clears that flag. Writing zero leaves it unchanged. A flag set by an event in the same edge wins over the clear.
- R8: When a compare match and an overflow fall on the same tick (compare equals all-ones), both flags are set and `pwm_out` keeps its level.
- R9: While disabled, the counter, `pwm_out` and both flags hold their values, apart from clears written by software.
- R10: Reset clears every register, the output and both requests. Address 0 reads back the control bits 4..0 and the flags at bits 8 and 9, with zeros elsewhere. Addresses 1 and 2 read back the load and compare values, and address 3 reads the capture value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer clock enable, one count per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 24 | Register write data |
| bus_rdata | output | 24 | Register read data for `bus_addr` |
| pwm_out | output | 1 | Modulated output |
| cmp_irq | output | 1 | Compare interrupt request, level |
| ovf_irq | output | 1 | Overflow interrupt request, level |

## Verification
A compare match and a full-scale overflow share one tick only when the compare value is all-ones. The bench programs exactly that, with a load a few counts below full scale. It then expects `pwm_out` to stay at its start level for the whole run while both flags come up. A second collision comes from holding a write-one-to-clear of the compare flag on the bus across several periods. The behavioural model in the bench expects the flag to stay set on every edge where a match arrives during the clear.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int ADDR_W = 2;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CAPT = 2'd3;

  // control word bit positions
  localparam int B_EN    = 0;
  localparam int B_INV   = 2;
  localparam int B_CFLAG = 8;
  localparam int B_OFLAG = 9;

  // packed so that en sits at bit 0 and ovf_ie at bit 4
  typedef struct packed {
    logic ovf_ie;
    logic cmp_ie;
    logic inv;
    logic reload;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // output level after one edge carrying the given events
  function automatic logic out_after(input logic cur, input logic hit_c, input logic hit_o);
    return cur ^ hit_c ^ hit_o;
  endfunction

  // flag after one edge: set wins over a write-one clear
  function automatic logic flag_after(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/pwm_tmr_cnt.sv
module pwm_tmr_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_cmp,
  output logic             hit_ovf
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] ld,
                                                input logic rl);
    if (c == CNT_TOP) return rl ? ld : '0;
    return c + 1'b1;
  endfunction

  logic step;
  assign step    = run & tick & ~start;
  assign hit_cmp = step & (cnt == cmp_val);
  assign hit_ovf = step & (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= load_val;
    else if (step)  cnt <= next_cnt(cnt, load_val, reload);
  end
endmodule

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              hit_cmp,
  input  logic              hit_ovf,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [CNT_W-1:0]  capt,
  output logic              start,
  output logic              start_inv,
  output logic              cmp_flag,
  output logic              ovf_flag,
  output logic              cmp_irq,
  output logic              ovf_irq,
  output logic [CNT_W-1:0]  bus_rdata
);
  logic wr_ctrl, clr_c, clr_o;
  assign wr_ctrl   = bus_we & (bus_addr == A_CTRL);
  assign start     = wr_ctrl & bus_wdata[B_EN] & ~ctrl.en;
  assign start_inv = bus_wdata[B_INV];
  assign clr_c     = wr_ctrl & bus_wdata[B_CFLAG];
  assign clr_o     = wr_ctrl & bus_wdata[B_OFLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      load_val <= '0;
      cmp_val  <= '0;
      capt     <= '0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (bus_we && bus_addr == A_LOAD) load_val <= bus_wdata;
      if (bus_we && bus_addr == A_CMP)  cmp_val  <= bus_wdata;
      if (hit_cmp) capt <= cnt;
      cmp_flag <= flag_after(cmp_flag, clr_c, hit_cmp);
      ovf_flag <= flag_after(ovf_flag, clr_o, hit_ovf);
    end
  end

  assign cmp_irq = cmp_flag & ctrl.cmp_ie;
  assign ovf_irq = ovf_flag & ctrl.ovf_ie;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CTRL_W-1:0] = ctrl;
        bus_rdata[B_CFLAG]    = cmp_flag;
        bus_rdata[B_OFLAG]    = ovf_flag;
      end
      A_LOAD:  bus_rdata = load_val;
      A_CMP:   bus_rdata = cmp_val;
      default: bus_rdata = capt;
    endcase
  end
endmodule

// File: rtl/pwm_tmr_out.sv
module pwm_tmr_out
  import pwm_tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_inv,
  input  logic hit_cmp,
  input  logic hit_ovf,
  output logic pwm_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pwm_out <= 1'b0;
    else if (start) pwm_out <= start_inv;
    else            pwm_out <= out_after(pwm_out, hit_cmp, hit_ovf);
  end
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             pwm_out,
  output logic             cmp_irq,
  output logic             ovf_irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_val, cmp_val, capt, cnt;
  logic             start, start_inv, hit_cmp, hit_ovf, cmp_flag, ovf_flag;

  pwm_tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .hit_cmp(hit_cmp), .hit_ovf(hit_ovf), .cnt(cnt),
    .ctrl(ctrl), .load_val(load_val), .cmp_val(cmp_val), .capt(capt),
    .start(start), .start_inv(start_inv), .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq),
    .bus_rdata(bus_rdata)
  );

  pwm_tmr_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl.en), .start(start), .tick(tick),
    .reload(ctrl.reload), .load_val(load_val), .cmp_val(cmp_val),
    .cnt(cnt), .hit_cmp(hit_cmp), .hit_ovf(hit_ovf)
  );

  pwm_tmr_out out_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_inv(start_inv),
    .hit_cmp(hit_cmp), .hit_ovf(hit_ovf), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             reload,
  input logic             tick,
  input logic             start,
  input logic             start_inv,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] capt,
  input logic             hit_cmp,
  input logic             hit_ovf,
  input logic             cmp_flag,
  input logic             ovf_flag,
  input logic             cmp_irq,
  input logic             ovf_irq,
  input logic             pwm_out
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(run && tick)) |=> $stable(cnt));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !start && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);

  // R2
  start_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pwm_out == $past(start_inv)) && (cnt == $past(load_val)));

  // R3
  cmp_capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cmp |=> cmp_flag && (capt == $past(cnt)));

  // R3
  cmp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmp && !hit_ovf) |=> pwm_out != $past(pwm_out));

  // R4
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ovf && reload) |=> ovf_flag && (cnt == $past(load_val)));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_irq |-> cmp_flag) and (ovf_irq |-> ovf_flag));

  // R8
  both_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmp && hit_ovf) |=> pwm_out == $past(pwm_out));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(pwm_out) && !$rose(cmp_flag) && !$rose(ovf_flag));
endmodule

bind pwm_timer_chan pwm_tmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(ctrl.en), .reload(ctrl.reload), .tick(tick),
  .start(start), .start_inv(start_inv), .cnt(cnt), .load_val(load_val),
  .capt(capt), .hit_cmp(hit_cmp), .hit_ovf(hit_ovf), .cmp_flag(cmp_flag),
  .ovf_flag(ovf_flag), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .pwm_out(pwm_out)
);

// File: tb/pwm_timer_chan_tb_top.sv
module pwm_timer_chan_tb_top;
  localparam int CNT_W = 24;
  localparam int unsigned TOP = 32'h00FF_FFFF;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             bus_we = 1'b0;
  logic [1:0]       bus_addr = 2'd0;
  logic [CNT_W-1:0] bus_wdata = '0;
  logic [CNT_W-1:0] bus_rdata;
  logic             pwm_out, cmp_irq, ovf_irq;

  always #4 clk = ~clk;

  pwm_timer_chan #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string phase = "R10";
  bit    model_on = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // behavioural reference model
  int unsigned m_cnt, m_load, m_cmp, m_cap;
  bit m_en, m_rel, m_inv, m_cie, m_oie, m_cf, m_of, m_out;
  bit g_wc, g_st, g_go, g_mt, g_ov;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_cmp = 0; m_cap = 0;
      m_en = 0; m_rel = 0; m_inv = 0; m_cie = 0; m_oie = 0;
      m_cf = 0; m_of = 0; m_out = 0;
    end else begin
      g_wc = bus_we && bus_addr == 2'd0;
      g_st = g_wc && bus_wdata[0] && !m_en;
      g_go = m_en && tick && !g_st;
      g_mt = g_go && (m_cnt == m_cmp);
      g_ov = g_go && (m_cnt == TOP);
      if (g_mt) m_cap = m_cnt;
      if (g_st) m_cnt = m_load;
      else if (g_go) m_cnt = g_ov ? (m_rel ? m_load : 0) : m_cnt + 1;
      if (g_st) m_out = bus_wdata[2];
      else begin
        if (g_mt) m_out = !m_out;
        if (g_ov) m_out = !m_out;
      end
      if (g_wc && bus_wdata[8]) m_cf = 0;
      if (g_wc && bus_wdata[9]) m_of = 0;
      if (g_mt) m_cf = 1;
      if (g_ov) m_of = 1;
      if (g_wc) begin
        m_en = bus_wdata[0]; m_rel = bus_wdata[1]; m_inv = bus_wdata[2];
        m_cie = bus_wdata[3]; m_oie = bus_wdata[4];
      end
      if (bus_we && bus_addr == 2'd1) m_load = 32'(bus_wdata);
      if (bus_we && bus_addr == 2'd2) m_cmp = 32'(bus_wdata);
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {22'd0, m_of, m_cf, 3'd0, m_oie, m_cie, m_inv, m_rel, m_en};
      2'd1: return m_load;
      2'd2: return m_cmp;
      default: return m_cap;
    endcase
  endfunction

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check(phase, {29'd0, pwm_out, cmp_irq, ovf_irq},
            {29'd0, m_out, m_cf && m_cie, m_of && m_oie});
      check(phase, 32'(bus_rdata), exp_rd(bus_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected under 50000", cyc);
      finish_up();
    end
  end

  // drivers change inputs 1 ns after a rising edge
  task automatic wr(input logic [1:0] a, input int unsigned d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d[CNT_W-1:0];
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] mask,
                        input logic [31:0] exp);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(req, 32'(bus_rdata) & mask, exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
    end
  endtask

  task automatic run_idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int hi;
  int tg;
  logic last;

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", {29'd0, pwm_out, cmp_irq, ovf_irq}, 32'd0);
    check("R10", 32'(bus_rdata), 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    model_on = 1'b1;
    rd_chk("R10", 2'd3, 32'hFF_FFFF, 32'd0);
    wr(2'd1, TOP - 15);
    wr(2'd2, TOP - 7);
    rd_chk("R10", 2'd1, 32'hFF_FFFF, TOP - 15);
    rd_chk("R10", 2'd2, 32'hFF_FFFF, TOP - 7);

    // R2 / R5: start with invert clear, reload and both interrupt enables on
    phase = "R5";
    @(posedge clk); #1; tick = 1'b1;
    wr(2'd0, 32'h1B);
    @(negedge clk);
    check("R2", 32'(pwm_out), 32'd0);
    hi = 0; tg = 0; last = pwm_out;
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_out != last) tg++;
      last = pwm_out;
    end
    check("R5", hi, 14);
    check("R5", tg, 4);
    check("R6", {30'd0, cmp_irq, ovf_irq}, 32'd3);

    // R6: enables off, flags remain
    phase = "R6";
    wr(2'd0, 32'h03);
    @(negedge clk);
    check("R6", {30'd0, cmp_irq, ovf_irq}, 32'd0);
    rd_chk("R6", 2'd0, 32'h300, 32'h300);

    // R7: write-one clears, one flag at a time
    phase = "R7";
    @(posedge clk); #1; tick = 1'b0;
    wr(2'd0, 32'h103);
    rd_chk("R7", 2'd0, 32'h300, 32'h200);
    wr(2'd0, 32'h203);
    rd_chk("R7", 2'd0, 32'h300, 32'h000);

    // R1 / R3 / R4: single ticks from a fresh start
    phase = "R1";
    wr(2'd0, 32'h02);
    wr(2'd0, 32'h03);
    pulses(8);
    @(negedge clk);
    check("R1", 32'(pwm_out), 32'd0);
    phase = "R3";
    pulses(1);
    @(negedge clk);
    check("R3", 32'(pwm_out), 32'd1);
    rd_chk("R3", 2'd3, 32'hFF_FFFF, TOP - 7);
    rd_chk("R3", 2'd0, 32'h100, 32'h100);
    phase = "R4";
    pulses(6);
    @(negedge clk);
    check("R1", 32'(pwm_out), 32'd1);
    pulses(1);
    @(negedge clk);
    check("R4", 32'(pwm_out), 32'd0);
    rd_chk("R4", 2'd0, 32'h200, 32'h200);
    pulses(9);
    @(negedge clk);
    check("R4", 32'(pwm_out), 32'd1);

    // R9: disabled channel holds output and flags
    phase = "R9";
    wr(2'd0, 32'h302);
    @(negedge clk);
    last = pwm_out;
    @(posedge clk); #1; tick = 1'b1;
    run_idle(40);
    @(negedge clk);
    check("R9", 32'(pwm_out), 32'(last));
    rd_chk("R9", 2'd0, 32'h300, 32'h000);

    // R2 / R5: inverted start
    phase = "R5";
    wr(2'd0, 32'h07);
    @(negedge clk);
    check("R2", 32'(pwm_out), 32'd1);
    hi = 0;
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); @(negedge clk);
      if (pwm_out) hi++;
    end
    check("R5", hi, 18);

    // R4: reload off wraps through zero
    phase = "R4";
    wr(2'd0, 32'h02);
    wr(2'd1, TOP - 3);
    wr(2'd2, TOP - 1);
    wr(2'd0, 32'h301);
    run_idle(10);
    @(negedge clk);
    check("R4", 32'(pwm_out), 32'd0);
    rd_chk("R4", 2'd0, 32'h300, 32'h300);
    tg = 0; last = pwm_out;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); @(negedge clk);
      if (pwm_out != last) tg++;
      last = pwm_out;
    end
    check("R4", tg, 0);

    // R8: match and overflow on the same tick
    phase = "R8";
    wr(2'd0, 32'h302);
    wr(2'd1, TOP - 5);
    wr(2'd2, TOP);
    wr(2'd0, 32'h03);
    tg = 0; last = pwm_out;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (pwm_out != last) tg++;
      last = pwm_out;
    end
    check("R8", tg, 0);
    check("R8", 32'(pwm_out), 32'd0);
    rd_chk("R8", 2'd0, 32'h300, 32'h300);

    // R7: clear held on the bus across several periods, events win
    phase = "R7";
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 24'h103;
    run_idle(30);
    bus_we = 1'b0;
    run_idle(8);
    rd_chk("R7", 2'd0, 32'h100, 32'h100);

    run_idle(4);
    finish_up();
  end
endmodule